// File: doc/BRIEF.md
# Single-wire debug target interface

This block is the target end of a half-duplex debug link carried on one pseudo-open-drain pad with an internal pullup, so an undriven line reads high. The host opens every bit cell with a falling edge, whichever way the bit travels. In a receive cell the block samples the line at a fixed cell cycle. In a transmit cell it either holds the line low past the host's own pulse (a 0) or leaves it alone (a 1). After any low period it drives the pad, it pushes the line high for one clock to sharpen the rising edge, then releases it. All cell timing runs on the debug clock, which equals the bus clock.

A host that does not know the target clock holds the line low for a long time. After the host lets go, the target answers with a low pulse of fixed length. The host measures that pulse to learn the clock rate. While any reset is asserted, the pad level is captured to choose the start mode. A low pad means halted debug mode and a high pad (the pullup default) means normal run mode. Bytes move most significant bit first. A loaded byte is sent over the next eight cells, and received bytes come out with a one-cycle strobe. Drive enable and drive value are separate outputs so that an external tri-state pad can be modelled.

Timing convention used below: E0 is the clock edge just before the host pulls the pad low, and "cell cycle n" is the clock period after edge E0+SYNC_STAGES+n (defaults SYNC_STAGES=2, SAMPLE_AT=10, TX_HOLD=13, SYNC_DET=128, SYNC_GAP=16, SYNC_LOW=128).

Top module: `owd_target`

## Requirements
- R1: The pad level at the last clock edge with rst_n low sets halt_mode: low pad gives halt_mode=1, high pad gives halt_mode=0.
- R2: While soft_rst is high, halt_mode is resampled from the pad in the same way, and any partly received or partly sent byte is discarded.
- R3: After reset, with the line idle, drive_en and drive_val are 0, and drive_val is never 1 without drive_en.
- R4: In a receive cell the bit is the pad level at edge E0+SAMPLE_AT+1 (high = 1). Bits enter MSB first, and after the eighth bit rx_byte holds the byte while rx_valid pulses for exactly cell cycle SAMPLE_AT+1.
- R5: In a transmit cell whose bit is 0, drive_en=1 and drive_val=0 for cell cycles 1 to TX_HOLD-1.
- R6: After a transmitted 0 the block drives drive_en=1, drive_val=1 for cell cycle TX_HOLD only, and releases the pad (drive_en=0) in cell cycle TX_HOLD+1. It never drives high while the host holds the line low.
- R7: In a transmit cell whose bit is 1, drive_en stays 0 for the whole cell.
- R8: A tx_load pulse with no byte in flight starts a transmission of tx_byte, MSB first, over the next eight cells. tx_done pulses in cell cycle TX_HOLD+1 of the eighth cell, and later cells are receive cells.
- R9: A tx_load pulse while a byte is still being sent is ignored.
- R10: If the host held the line low for at least SYNC_DET clocks and releases it between edges Er and Er+1, the block drives low from the period after edge Er+SYNC_STAGES+1+SYNC_GAP for SYNC_LOW clocks, drives high for one clock, then releases.
- R11: A low period shorter than SYNC_DET clocks produces no sync response and no drive.
- R12: A sync request discards a partly received byte, so the next eight cells form a whole new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock, same frequency as the bus clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Debug-issued reset, active high, synchronous |
| pad_in | input | 1 | Level read back from the shared pad |
| drive_en | output | 1 | 1 = target drives the pad |
| drive_val | output | 1 | Level driven when drive_en is 1 |
| halt_mode | output | 1 | 1 = start in halted debug mode |
| tx_load | input | 1 | Load strobe for a byte to send |
| tx_byte | input | BYTE_W | Byte to send |
| tx_done | output | 1 | One-cycle pulse after the last bit is sent |
| rx_byte | output | BYTE_W | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is new |

## Verification
A cell counter that is off by one shows at the pad within one bit cell. The speedup pulse lands a cycle early or late, or it overlaps the host's own low and the pad model flags a conflict. A bit counter left stale after a sync or soft reset shows only at the end of the following byte, as a wrong or early rx_valid. The byte scoreboard therefore follows every reset or sync with a full byte. A sync sequencer that miscounts moves the start or end of the answer pulse, and the bench measures both to the exact clock.

// File: rtl/owd_pkg.sv
package owd_pkg;
   typedef enum logic [1:0] {
      SR_IDLE = 2'd0,
      SR_GAP  = 2'd1,
      SR_LOW  = 2'd2,
      SR_SPD  = 2'd3
   } sr_state_e;
endpackage

// File: rtl/owd_line_sync.sv
module owd_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_in,
   output logic line,
   output logic fall,
   output logic rise
);
   if (STAGES < 1) begin : g_bad_stages
      $error("owd_line_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sq;
   logic              line_d;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sq <= 1'b1;
         else        sq <= pad_in;
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sq <= '1;
         else        sq <= {sq[STAGES-2:0], pad_in};
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) line_d <= 1'b1;
      else        line_d <= line;

   assign line = sq[STAGES-1];
   assign fall = line_d & ~line;
   assign rise = ~line_d & line;
endmodule

// File: rtl/owd_cell.sv
module owd_cell #(
   parameter int BYTE_W    = 8,
   parameter int SAMPLE_AT = 10,
   parameter int TX_HOLD   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fall,
   input  logic              line,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              tx_done,
   output logic              drv_low,
   output logic              drv_high
);
   localparam int CW  = $clog2(TX_HOLD + 1);
   localparam int BCW = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;

   if (SAMPLE_AT < 2 || SAMPLE_AT >= TX_HOLD) begin : g_bad_sample
      $error("owd_cell: SAMPLE_AT must lie in 2..TX_HOLD-1");
   end
   if (BYTE_W < 2) begin : g_bad_width
      $error("owd_cell: BYTE_W must be at least 2");
   end

   logic              active, cell_tx, cell_bit, tx_busy;
   logic [CW-1:0]     cyc;
   logic [BYTE_W-1:0] tx_sh, rx_sh;
   logic [BCW-1:0]    tx_cnt, rx_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;  cyc <= '0;  cell_tx <= 1'b0;  cell_bit <= 1'b0;
         tx_sh <= '0;  tx_busy <= 1'b0;  tx_cnt <= '0;  tx_done <= 1'b0;
         rx_sh <= '0;  rx_cnt <= '0;  rx_byte <= '0;  rx_valid <= 1'b0;
         drv_low <= 1'b0;  drv_high <= 1'b0;
      end else if (clr) begin
         active <= 1'b0;  cyc <= '0;  cell_tx <= 1'b0;  cell_bit <= 1'b0;
         tx_sh <= '0;  tx_busy <= 1'b0;  tx_cnt <= '0;  tx_done <= 1'b0;
         rx_sh <= '0;  rx_cnt <= '0;  rx_valid <= 1'b0;
         drv_low <= 1'b0;  drv_high <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_done  <= 1'b0;
         if (tx_load && !tx_busy) begin
            tx_sh   <= tx_byte;
            tx_busy <= 1'b1;
            tx_cnt  <= '0;
         end
         if (fall) begin
            active   <= 1'b1;
            cyc      <= CW'(1);
            cell_tx  <= tx_busy;
            cell_bit <= tx_sh[BYTE_W-1];
            drv_low  <= tx_busy & ~tx_sh[BYTE_W-1];
            drv_high <= 1'b0;
         end else if (active) begin
            cyc <= cyc + CW'(1);
            if (cyc == CW'(SAMPLE_AT) && !cell_tx) begin
               rx_sh <= {rx_sh[BYTE_W-2:0], line};
               if (rx_cnt == BCW'(BYTE_W-1)) begin
                  rx_byte  <= {rx_sh[BYTE_W-2:0], line};
                  rx_valid <= 1'b1;
                  rx_cnt   <= '0;
               end else begin
                  rx_cnt <= rx_cnt + BCW'(1);
               end
            end
            if (cyc == CW'(TX_HOLD-1)) begin
               drv_low  <= 1'b0;
               drv_high <= cell_tx & ~cell_bit;
            end
            if (cyc == CW'(TX_HOLD)) begin
               drv_high <= 1'b0;
               active   <= 1'b0;
               if (cell_tx) begin
                  tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                  if (tx_cnt == BCW'(BYTE_W-1)) begin
                     tx_busy <= 1'b0;
                     tx_done <= 1'b1;
                  end else begin
                     tx_cnt <= tx_cnt + BCW'(1);
                  end
               end
            end
         end
      end
   end

   // R5
   tx_low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_low |-> (active && cyc < CW'(TX_HOLD)));
   // R6
   cell_speedup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_high) |-> $past(drv_low));
   // R7
   tx_one_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_low |-> (cell_tx && !cell_bit));
endmodule

// File: rtl/owd_sync_resp.sv
module owd_sync_resp
   import owd_pkg::*;
#(
   parameter int DET_LEN = 128,
   parameter int GAP_LEN = 16,
   parameter int LOW_LEN = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic line,
   input  logic rise,
   output logic start,
   output logic busy,
   output logic drv_low,
   output logic drv_high
);
   localparam int LCW  = $clog2(DET_LEN + 1);
   localparam int MAXP = (GAP_LEN > LOW_LEN) ? GAP_LEN : LOW_LEN;
   localparam int PCW  = $clog2(MAXP + 1);

   if (DET_LEN < 2 || GAP_LEN < 1 || LOW_LEN < 1) begin : g_bad_len
      $error("owd_sync_resp: lengths out of range");
   end

   sr_state_e      state;
   logic [LCW-1:0] low_cnt;
   logic [PCW-1:0] pc;

   assign start    = (state == SR_IDLE) && rise && (low_cnt == LCW'(DET_LEN));
   assign busy     = (state != SR_IDLE);
   assign drv_low  = (state == SR_LOW);
   assign drv_high = (state == SR_SPD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SR_IDLE;  low_cnt <= '0;  pc <= '0;
      end else if (clr) begin
         state <= SR_IDLE;  low_cnt <= '0;  pc <= '0;
      end else begin
         if (busy || line)                   low_cnt <= '0;
         else if (low_cnt != LCW'(DET_LEN))  low_cnt <= low_cnt + LCW'(1);
         case (state)
            SR_IDLE: if (start) begin state <= SR_GAP; pc <= '0; end
            SR_GAP:
               if (pc == PCW'(GAP_LEN-1)) begin state <= SR_LOW; pc <= '0; end
               else pc <= pc + PCW'(1);
            SR_LOW:
               if (pc == PCW'(LOW_LEN-1)) begin state <= SR_SPD; pc <= '0; end
               else pc <= pc + PCW'(1);
            default: state <= SR_IDLE;
         endcase
      end
   end

   // R10
   sr_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SR_LOW) |-> (pc < PCW'(LOW_LEN)));
   // R10
   sr_speedup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_high) |-> $past(drv_low));
   // R11
   sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SR_GAP && $past(state) == SR_IDLE) |-> ($past(low_cnt) == LCW'(DET_LEN)));
endmodule

// File: rtl/owd_target.sv
module owd_target #(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   parameter int SAMPLE_AT   = 10,
   parameter int TX_HOLD     = 13,
   parameter int SYNC_DET    = 128,
   parameter int SYNC_GAP    = 16,
   parameter int SYNC_LOW    = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              pad_in,
   output logic              drive_en,
   output logic              drive_val,
   output logic              halt_mode,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              tx_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid
);
   if (SYNC_DET <= TX_HOLD + SYNC_STAGES + 1) begin : g_bad_det
      $error("owd_target: SYNC_DET must exceed a transmit low period");
   end

   logic line, fall, rise;
   logic sr_start, sr_busy, sr_low, sr_high;
   logic c_low, c_high;
   logic halt_q;

   owd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
      .line(line), .fall(fall), .rise(rise)
   );

   owd_sync_resp #(.DET_LEN(SYNC_DET), .GAP_LEN(SYNC_GAP), .LOW_LEN(SYNC_LOW)) u_resp (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .line(line), .rise(rise),
      .start(sr_start), .busy(sr_busy), .drv_low(sr_low), .drv_high(sr_high)
   );

   owd_cell #(.BYTE_W(BYTE_W), .SAMPLE_AT(SAMPLE_AT), .TX_HOLD(TX_HOLD)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst | sr_start),
      .fall(fall & ~sr_busy), .line(line),
      .tx_load(tx_load), .tx_byte(tx_byte),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_done(tx_done),
      .drv_low(c_low), .drv_high(c_high)
   );

   always_ff @(posedge clk)
      if (!rst_n || soft_rst) halt_q <= ~pad_in;

   assign halt_mode = halt_q;
   assign drive_en  = c_low | c_high | sr_low | sr_high;
   assign drive_val = c_high | sr_high;

   // R3
   drive_val_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_val |-> drive_en);
   // R10
   single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({c_low, c_high, sr_low, sr_high}));
   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !soft_rst && !$past(soft_rst)) |-> $stable(halt_mode));
endmodule

// File: tb/owd_target_tb_top.sv
module owd_target_tb_top;
   localparam int CLK_NS = 10;
   localparam int CS     = 2;   // synchronizer stages of the DUT

   logic       clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, host_low = 1'b0;
   logic       tx_load = 1'b0;
   logic [7:0] tx_byte = '0;
   logic       drive_en, drive_val, halt_mode, tx_done, rx_valid, pad;
   logic [7:0] rx_byte;

   int nchk = 0, nfail = 0, conflicts = 0, txdone_cnt = 0;
   bit reported = 1'b0;
   logic [7:0] exp_rx[$];

   always #(CLK_NS/2) clk = ~clk;

   assign pad = drive_en ? drive_val : ~host_low;

   owd_target dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pad_in(pad),
      .drive_en(drive_en), .drive_val(drive_val), .halt_mode(halt_mode),
      .tx_load(tx_load), .tx_byte(tx_byte), .tx_done(tx_done),
      .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected bytes as the design delivers them
   always @(negedge clk) begin
      logic [7:0] e;
      if (rst_n && !soft_rst) begin
         if (rx_valid) begin
            if (exp_rx.size() == 0) chk(1'b0, "R4 unexpected rx_valid", rx_byte, 0);
            else begin
               e = exp_rx.pop_front();
               chk(rx_byte == e, "R4 received byte", rx_byte, e);
            end
         end
         if (tx_done) txdone_cnt++;
         if (host_low && drive_en && drive_val) conflicts++;
      end
   end

   task automatic por(input bit pad_low);
      @(negedge clk);
      rst_n = 1'b0;  host_low = pad_low;
      cyc(5);
      rst_n = 1'b1;  host_low = 1'b0;
      cyc(3);
   endtask

   task automatic host_write_bit(input bit b);
      @(negedge clk) host_low = 1'b1;
      cyc(b ? 4 : 16);
      host_low = 1'b0;
      cyc(8);
   endtask

   task automatic host_send(input logic [7:0] v);
      exp_rx.push_back(v);
      for (int i = 7; i >= 0; i--) host_write_bit(v[i]);
   endtask

   // one cell read by the host; k counts negedges after the host's fall
   task automatic host_read_bit(output bit b, output bit ok, output int dk);
      bit de[1:20];
      bit dv[1:20];
      b = 1'b1;  dk = 0;
      @(negedge clk) host_low = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         de[k] = drive_en;  dv[k] = drive_val;
         if (tx_done) dk = k;
         if (k == 10) b = pad;
         if (k == 4) host_low = 1'b0;
      end
      ok = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         if (b == 1'b1) begin
            if (de[k]) ok = 1'b0;
         end else if (k >= CS + 1 && k <= CS + 12) begin
            if (!de[k] || dv[k]) ok = 1'b0;
         end else if (k == CS + 13) begin
            if (!de[k] || !dv[k]) ok = 1'b0;
         end else if (de[k]) ok = 1'b0;
      end
   endtask

   task automatic host_recv(output logic [7:0] v, output int bad, output int last_dk, output int early_dk);
      bit b, ok;
      int dk;
      bad = 0;  early_dk = 0;  last_dk = 0;
      for (int i = 7; i >= 0; i--) begin
         host_read_bit(b, ok, dk);
         v[i] = b;
         if (!ok) bad++;
         if (i == 0) last_dk = dk;
         else if (dk != 0) early_dk++;
      end
   endtask

   task automatic host_sync(input int low_len, output int first_low, output int n_low,
                            output int spd_k, output int last_de);
      first_low = 0;  n_low = 0;  spd_k = 0;  last_de = 0;
      @(negedge clk) host_low = 1'b1;
      cyc(low_len);
      host_low = 1'b0;
      for (int k = 1; k <= 170; k++) begin
         @(negedge clk);
         if (drive_en && !drive_val) begin
            n_low++;
            if (first_low == 0) first_low = k;
         end
         if (drive_en && drive_val) spd_k = k;
         if (drive_en) last_de = k;
      end
   endtask

   initial begin
      #(CLK_NS * 100000);
      chk(1'b0, "watchdog expired", 0, 1);
      report();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int bad, ldk, edk, d0, fl, nl, sk, ld, cnt;
      bit b, ok;

      // R1 R3: power-on with the pad pulled high
      por(1'b0);
      chk(halt_mode == 1'b0, "R1 run mode after high pad", halt_mode, 0);
      chk(drive_en == 1'b0 && drive_val == 1'b0, "R3 idle drive", {drive_en, drive_val}, 0);

      // R4: host writes bytes
      host_send(8'hA5);
      host_send(8'h3C);
      cyc(4);
      chk(exp_rx.size() == 0, "R4 all bytes delivered", exp_rx.size(), 0);

      // R5 R6 R7 R8: target sends a byte
      @(negedge clk) begin tx_load = 1'b1; tx_byte = 8'h96; end
      @(negedge clk) tx_load = 1'b0;
      d0 = txdone_cnt;
      host_recv(v, bad, ldk, edk);
      chk(v == 8'h96, "R7 R5 byte read by host", v, 8'h96);
      chk(bad == 0, "R5 R6 R7 drive timing per cell", bad, 0);
      chk(ldk == CS + 14 && edk == 0, "R8 tx_done position", ldk, CS + 14);
      chk(txdone_cnt == d0 + 1, "R8 single tx_done", txdone_cnt - d0, 1);

      // R9: second load while busy is ignored
      @(negedge clk) begin tx_load = 1'b1; tx_byte = 8'h5A; end
      @(negedge clk) tx_load = 1'b0;
      fork
         host_recv(v, bad, ldk, edk);
         begin
            cyc(30);
            tx_load = 1'b1;  tx_byte = 8'h00;
            cyc(1);
            tx_load = 1'b0;
         end
      join
      chk(v == 8'h5A, "R9 byte kept during busy load", v, 8'h5A);
      host_read_bit(b, ok, ldk);
      chk(b == 1'b1 && ok, "R9 R8 cell after byte is receive", b, 1);

      // R11: low shorter than the sync threshold
      @(negedge clk) host_low = 1'b1;
      cyc(60);
      host_low = 1'b0;
      cnt = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (drive_en) cnt++;
      end
      chk(cnt == 0, "R11 no response to short low", cnt, 0);

      // R10: sync request and timed answer
      host_sync(140, fl, nl, sk, ld);
      chk(fl == CS + 1 + 16, "R10 answer start", fl, CS + 17);
      chk(nl == 128, "R10 answer length", nl, 128);
      chk(sk == CS + 1 + 16 + 128, "R10 speedup cycle", sk, CS + 145);
      chk(ld == sk, "R10 released after speedup", ld, sk);

      // R12: partial byte dropped by sync
      host_write_bit(1'b1);
      host_write_bit(1'b0);
      host_write_bit(1'b1);
      host_sync(140, fl, nl, sk, ld);
      cyc(5);
      host_send(8'hC3);
      cyc(4);
      chk(exp_rx.size() == 0, "R12 whole byte after sync", exp_rx.size(), 0);

      // R1: power-on with the pad held low
      por(1'b1);
      chk(halt_mode == 1'b1, "R1 halt mode after low pad", halt_mode, 1);
      chk(drive_en == 1'b0, "R3 idle after reset", drive_en, 0);

      // R2: debug reset resamples and clears a partial byte
      host_write_bit(1'b0);
      host_write_bit(1'b0);
      @(negedge clk) soft_rst = 1'b1;
      cyc(3);
      soft_rst = 1'b0;
      cyc(2);
      chk(halt_mode == 1'b0, "R2 resampled mode", halt_mode, 0);
      host_send(8'h7E);
      cyc(4);
      chk(exp_rx.size() == 0, "R2 clean byte after soft reset", exp_rx.size(), 0);

      chk(conflicts == 0, "R6 speedup never fights host low", conflicts, 0);
      report();
      $finish;
   end
endmodule